// File: doc/BRIEF.md
# Four-bit register file with feedback ALU

This block is a small 4-bit datapath. Eight storage registers share one write port and two read ports. An arithmetic and logic unit sits on the two read ports. Its result can be steered back into the write port, so a value loaded from outside can be refined over several clock steps without leaving the block.

Each cycle the caller picks two registers to read and one ALU function. It can also write one register. The write data is one of three things: the external data word, the ALU result, or a zero constant. Reads are combinational. Writes land on the rising clock edge. A synchronous reset clears every register.

Top module: `rfalu_top`

## Requirements
- R1: When `rst` is high at a rising edge, every register holds 0 after that edge, even if a write is requested in the same cycle.
- R2: With `wrEn` high, the register named by `wrAddr` takes the selected write data at the rising edge. All other registers keep their values.
- R3: With `wrEn` low, no register changes, whatever the other write inputs are.
- R4: Both read ports are combinational. Reading a register in the cycle it is being written returns the value it held before the edge.
- R5: Write source encoding on `wrSrcSel`: 0 and 3 select `extData`, 1 selects the ALU result, and 2 selects the constant 0.
- R6: `aluOpSel` 0 gives A + B modulo 16, where A is `rdDataA` and B is `rdDataB`. `aluCarry` is the carry out of bit 3.
- R7: `aluOpSel` 1 gives A − B modulo 16. `aluCarry` is 1 exactly when A < B (a borrow).
- R8: `aluOpSel` 2 gives A AND B, and `aluOpSel` 3 gives A OR B.
- R9: `aluOpSel` 4 gives NOT(A AND B), and `aluOpSel` 5 gives NOT(A OR B).
- R10: `aluOpSel` 6 and 7 pass A through unchanged. `aluCarry` is 0 for every opcode from 2 to 7.
- R11: Writing the ALU result back and reading it again on later cycles chains operations. For example, doubling a register twice gives 4·x modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| extData | input | 4 | Data word supplied from outside |
| wrSrcSel | input | 2 | Chooses the write data source |
| wrAddr | input | 3 | Register to be written |
| wrEn | input | 1 | Write request |
| rdAddrA | input | 3 | Register shown on read port A |
| rdAddrB | input | 3 | Register shown on read port B |
| aluOpSel | input | 3 | ALU function code |
| rdDataA | output | 4 | Read port A (ALU operand A) |
| rdDataB | output | 4 | Read port B (ALU operand B) |
| aluResult | output | 4 | ALU result |
| aluCarry | output | 1 | Carry for add, borrow for subtract, 0 otherwise |

## Verification
The assertions take the following for granted:
- Every select and address input carries a known 0/1 value at each clock edge.
- Reset is asserted before the first checked edge.
- The register count is a power of two, so every read and write address names a real register.

The stimulus stays inside these limits. The bench drives all fields at the falling edge, from a fully specified vector table and directed loops. It holds reset for two edges at the start. It only uses addresses 0 to 7.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;

  typedef enum logic [1:0] {
    SRC_EXT     = 2'b00,
    SRC_ALU     = 2'b01,
    SRC_ZERO    = 2'b10,
    SRC_EXT_ALT = 2'b11
  } wrSrc_e;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_AND    = 3'd2,
    OP_OR     = 3'd3,
    OP_NAND   = 3'd4,
    OP_NOR    = 3'd5,
    OP_PASS   = 3'd6,
    OP_PASS_B = 3'd7
  } aluOp_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic pickExt;
    logic pickAlu;
    logic pickZero;
    logic doAdd;
    logic doSub;
    logic doAnd;
    logic doOr;
    logic doNand;
    logic doNor;
    logic doPass;
  } ctrlStrobes_t;

endpackage

// File: rtl/rfalu_ctrl.sv
module rfalu_ctrl
  import rfalu_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [1:0]          wrSrcSel,
  input  logic [2:0]          aluOpSel,
  output logic [NUM_REGS-1:0] loadVec,
  output ctrlStrobes_t        strb
);

  // Address decoder: raises at most one load enable
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign loadVec[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  wrSrc_e srcSel;
  aluOp_e opSel;
  assign srcSel = wrSrc_e'(wrSrcSel);
  assign opSel  = aluOp_e'(aluOpSel);

  always_comb begin
    strb = '0;
    unique case (srcSel)
      SRC_ALU:  strb.pickAlu  = 1'b1;
      SRC_ZERO: strb.pickZero = 1'b1;
      default:  strb.pickExt  = 1'b1;
    endcase
    unique case (opSel)
      OP_ADD:  strb.doAdd  = 1'b1;
      OP_SUB:  strb.doSub  = 1'b1;
      OP_AND:  strb.doAnd  = 1'b1;
      OP_OR:   strb.doOr   = 1'b1;
      OP_NAND: strb.doNand = 1'b1;
      OP_NOR:  strb.doNor  = 1'b1;
      default: strb.doPass = 1'b1;
    endcase
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> $countones(loadVec) == 1);  // R2
  AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> loadVec == '0);  // R3
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot({strb.pickExt, strb.pickAlu, strb.pickZero}));  // R5
  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot({strb.doAdd, strb.doSub, strb.doAnd, strb.doOr,
             strb.doNand, strb.doNor, strb.doPass}));  // R10

endmodule

// File: rtl/rfalu_regfile.sv
module rfalu_regfile #(
  parameter int DATA_W   = 4,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] loadVec,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddrA,
  input  logic [ADDR_W-1:0]   rdAddrB,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB
);

  logic [DATA_W-1:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] nextVal;
    // Enable mux: recirculate unless loaded
    assign nextVal = loadVec[i] ? wrData : regQ[i];

    always_ff @(posedge clk) begin
      if (rst) regQ[i] <= '0;
      else     regQ[i] <= nextVal;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> regQ[i] == '0);  // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !loadVec[i] |=> $stable(regQ[i]));  // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      loadVec[i] |=> regQ[i] == $past(wrData));  // R2
  end

  // Combinational read multiplexers
  always_comb begin
    rdDataA = regQ[rdAddrA];
    rdDataB = regQ[rdAddrB];
  end

endmodule

// File: rtl/rfalu_alu.sv
module rfalu_alu
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] sumExt;
  logic [EXT_W-1:0] diffExt;
  assign sumExt  = {1'b0, opA} + {1'b0, opB};
  assign diffExt = {1'b0, opA} - {1'b0, opB};

  // AND-OR result mux over one-hot strobes
  always_comb begin
    result = ({DATA_W{strb.doAdd}}  & sumExt[DATA_W-1:0])
           | ({DATA_W{strb.doSub}}  & diffExt[DATA_W-1:0])
           | ({DATA_W{strb.doAnd}}  & (opA & opB))
           | ({DATA_W{strb.doOr}}   & (opA | opB))
           | ({DATA_W{strb.doNand}} & ~(opA & opB))
           | ({DATA_W{strb.doNor}}  & ~(opA | opB))
           | ({DATA_W{strb.doPass}} & opA);
    carryOut = (strb.doAdd & sumExt[DATA_W]) | (strb.doSub & diffExt[DATA_W]);
  end

  AST_BORROW_FLAG: assert property (@(posedge clk) disable iff (rst)
    strb.doSub |-> carryOut == (opA < opB));  // R7
  AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (rst)
    strb.doSub |-> DATA_W'(result + opB) == opA);  // R7
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (strb.doAnd | strb.doOr | strb.doNand | strb.doNor | strb.doPass) |-> !carryOut);  // R10
  AST_PASS_A: assert property (@(posedge clk) disable iff (rst)
    strb.doPass |-> result == opA);  // R10

endmodule

// File: rtl/rfalu_dp.sv
module rfalu_dp
  import rfalu_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strb,
  input  logic [NUM_REGS-1:0] loadVec,
  input  logic [DATA_W-1:0]   extData,
  input  logic [ADDR_W-1:0]   rdAddrA,
  input  logic [ADDR_W-1:0]   rdAddrB,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB,
  output logic [DATA_W-1:0]   aluResult,
  output logic                aluCarry
);

  logic [DATA_W-1:0] wrData;

  // Three-way write source mux, closes the feedback loop
  always_comb begin
    wrData = ({DATA_W{strb.pickExt}} & extData)
           | ({DATA_W{strb.pickAlu}} & aluResult);
  end

  rfalu_regfile #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_regfile (
    .clk    (clk),
    .rst    (rst),
    .loadVec(loadVec),
    .wrData (wrData),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB)
  );

  rfalu_alu #(
    .DATA_W(DATA_W)
  ) u_alu (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opA     (rdDataA),
    .opB     (rdDataB),
    .result  (aluResult),
    .carryOut(aluCarry)
  );

  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    strb.pickZero |-> wrData == '0);  // R5
  AST_FEEDBACK_PATH: assert property (@(posedge clk) disable iff (rst)
    strb.pickAlu |-> wrData == aluResult);  // R11

endmodule

// File: rtl/rfalu_top.sv
module rfalu_top
  import rfalu_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] extData,
  input  logic [1:0]        wrSrcSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [2:0]        aluOpSel,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] aluResult,
  output logic              aluCarry
);

  ctrlStrobes_t        strb;
  logic [NUM_REGS-1:0] loadVec;

  rfalu_ctrl #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrSrcSel(wrSrcSel),
    .aluOpSel(aluOpSel),
    .loadVec (loadVec),
    .strb    (strb)
  );

  rfalu_dp #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .loadVec  (loadVec),
    .extData  (extData),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .aluResult(aluResult),
    .aluCarry (aluCarry)
  );

endmodule

// File: tb/rfalu_top_tb.sv
`timescale 1ns/1ps
module rfalu_top_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] extData;
  logic [1:0] wrSrcSel;
  logic [2:0] wrAddr;
  logic       wrEn;
  logic [2:0] rdAddrA;
  logic [2:0] rdAddrB;
  logic [2:0] aluOpSel;
  logic [3:0] rdDataA;
  logic [3:0] rdDataB;
  logic [3:0] aluResult;
  logic       aluCarry;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rfalu_top u_dut (
    .clk      (clk),
    .rst      (rst),
    .extData  (extData),
    .wrSrcSel (wrSrcSel),
    .wrAddr   (wrAddr),
    .wrEn     (wrEn),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .aluOpSel (aluOpSel),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .aluResult(aluResult),
    .aluCarry (aluCarry)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] src;
    logic [2:0] wa;
    logic [3:0] ext;
    logic [2:0] ra;
    logic [2:0] rb;
    logic [2:0] op;
    logic [3:0] eA;
    logic [3:0] eB;
    logic [3:0] eR;
    logic       eC;
    logic [23:0] tag;
  } vec_t;

  localparam int NVEC = 18;
  // Outputs are checked before the edge; the write happens at that edge.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 3'd1, 4'h9, 3'd1, 3'd2, 3'd0, 4'h0, 4'h0, 4'h0, 1'b0, "R4 "},
    '{1'b1, 2'd3, 3'd2, 4'h5, 3'd1, 3'd2, 3'd0, 4'h9, 4'h0, 4'h9, 1'b0, "R5 "},
    '{1'b0, 2'd0, 3'd6, 4'hF, 3'd1, 3'd2, 3'd0, 4'h9, 4'h5, 4'hE, 1'b0, "R2 "},
    '{1'b1, 2'd1, 3'd3, 4'h0, 3'd1, 3'd2, 3'd0, 4'h9, 4'h5, 4'hE, 1'b0, "R11"},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd3, 3'd1, 3'd0, 4'hE, 4'h9, 4'h7, 1'b1, "R6 "},
    '{1'b1, 2'd1, 3'd4, 4'h0, 3'd2, 3'd1, 3'd1, 4'h5, 4'h9, 4'hC, 1'b1, "R7 "},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd1, 3'd2, 3'd1, 4'h9, 4'h5, 4'h4, 1'b0, "R7 "},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd4, 3'd1, 3'd2, 4'hC, 4'h9, 4'h8, 1'b0, "R8 "},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd4, 3'd2, 3'd3, 4'hC, 4'h5, 4'hD, 1'b0, "R8 "},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd4, 3'd2, 3'd4, 4'hC, 4'h5, 4'hB, 1'b0, "R9 "},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd1, 3'd2, 3'd5, 4'h9, 4'h5, 4'h2, 1'b0, "R9 "},
    '{1'b1, 2'd2, 3'd1, 4'hF, 3'd1, 3'd4, 3'd6, 4'h9, 4'hC, 4'h9, 1'b0, "R10"},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd1, 3'd4, 3'd7, 4'h0, 4'hC, 4'h0, 1'b0, "R5 "},
    '{1'b1, 2'd1, 3'd2, 4'h0, 3'd2, 3'd2, 3'd0, 4'h5, 4'h5, 4'hA, 1'b0, "R11"},
    '{1'b1, 2'd1, 3'd2, 4'h0, 3'd2, 3'd2, 3'd0, 4'hA, 4'hA, 4'h4, 1'b1, "R11"},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd2, 3'd3, 3'd0, 4'h4, 4'hE, 4'h2, 1'b1, "R6 "},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd3, 3'd3, 3'd1, 4'hE, 4'hE, 4'h0, 1'b0, "R7 "},
    '{1'b0, 2'd0, 3'd0, 4'h0, 3'd6, 3'd3, 3'd1, 4'h0, 4'hE, 4'h2, 1'b1, "R3 "}
  };

  task automatic check(input logic [23:0] tag, input string what,
                       input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic setIdle();
    wrEn = 1'b0; wrSrcSel = 2'd0; wrAddr = 3'd0; extData = 4'h0;
    rdAddrA = 3'd0; rdAddrB = 3'd0; aluOpSel = 3'd0;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    setIdle();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, all registers read zero
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rdAddrA = 3'(i); rdAddrB = 3'(7 - i);
      #1;
      check("R1 ", "reset rdDataA", {1'b0, rdDataA}, 5'h0);
      check("R1 ", "reset rdDataB", {1'b0, rdDataB}, 5'h0);
    end

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      wrEn = VECS[v].we; wrSrcSel = VECS[v].src; wrAddr = VECS[v].wa;
      extData = VECS[v].ext; rdAddrA = VECS[v].ra; rdAddrB = VECS[v].rb;
      aluOpSel = VECS[v].op;
      #1;
      check(VECS[v].tag, "rdDataA", {1'b0, rdDataA}, {1'b0, VECS[v].eA});
      check(VECS[v].tag, "rdDataB", {1'b0, rdDataB}, {1'b0, VECS[v].eB});
      check(VECS[v].tag, "aluResult", {1'b0, aluResult}, {1'b0, VECS[v].eR});
      check(VECS[v].tag, "aluCarry", {4'h0, aluCarry}, {4'h0, VECS[v].eC});
    end

    // R2: fill each register with a distinct value, then read all back
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrSrcSel = 2'd0; wrAddr = 3'(i); extData = 4'((i * 3 + 1) & 15);
    end
    @(negedge clk);
    setIdle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rdAddrA = 3'(i); rdAddrB = 3'(i);
      #1;
      check("R2 ", "distinct fill", {1'b0, rdDataA}, 5'((i * 3 + 1) & 15));
    end

    // R3: write inputs toggling with wrEn low leave register 5 untouched
    @(negedge clk);
    wrEn = 1'b0; wrSrcSel = 2'd0; wrAddr = 3'd5; extData = 4'h0;
    @(negedge clk);
    wrSrcSel = 2'd2; extData = 4'hF;
    @(negedge clk);
    setIdle(); rdAddrA = 3'd5;
    #1;
    check("R3 ", "no write when disabled", {1'b0, rdDataA}, 5'h0);

    // R1: reset wins over a simultaneous write
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; extData = 4'hF;
    @(negedge clk);
    rst = 1'b0; setIdle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rdAddrA = 3'(i);
      #1;
      check("R1 ", "cleared after reset", {1'b0, rdDataA}, 5'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule